// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the per-processor countdown timer of a local interrupt controller. Software programs it through a small synchronous register port. A start value goes into the load register. A divider code selects a tick rate of the core clock divided by a power of two. A timer vector entry holds a vector number, a suppress bit and a repeat bit. Each expiry produces a single-cycle interrupt request with the vector attached. Priority handling and delivery to other processors are left to the logic around the block.

Writing the load register starts a new count and restarts the tick divider. In single-shot use the count falls to zero, stays there, and one expiry follows one tick later. In repeating use the count runs from the start value down to zero and back, so one period lasts start value + 1 ticks. A start value of zero leaves the timer idle in both uses. The block also holds a few reset-defaulted neighbour registers (task priority, spurious vector, destination format and spare vector entries) that software expects to find beside the timer.

Top module: `lapic_timer`

## Requirements
- R1: After reset every vector entry reads 0x0001_0000 (suppressed, vector 0, single-shot), and the load, count and divider registers read 0. Task priority reads 0x00, spurious vector reads 0xFF and destination format reads 0xF.
- R2: The divider register uses write-data bits 3, 1 and 0 as a 3-bit code {b3,b1,b0}. Codes 0 to 6 give one tick every 2, 4, 8, 16, 32, 64 and 128 clocks, and code 7 gives one tick per clock. Ticks are counted from the clock edge that writes the load register.
- R3: In single-shot mode (entry bit 17 = 0) with start value N > 0, the count reads N - d after d ticks. It reads 0 from d = N onward.
- R4: A single-shot timer raises `irq_pulse` for exactly one clock after tick N + 1, with `irq_vector` equal to entry bits 7:0, and never again until the next load.
- R5: In repeating mode (entry bit 17 = 1) with N > 0, the count reads N - (d mod (N + 1)) and a pulse follows every tick where d is a nonzero multiple of N + 1.
- R6: In repeating mode a start value of 0 never produces a pulse, and the count reads 0.
- R7: Writing a start value of 0 stops a running single-shot timer with no pulse.
- R8: While entry bit 16 is set no pulse is produced, but counting continues, so clearing the bit lets pulses resume on the original schedule.
- R9: Rewriting the load register while the timer runs restarts the elapsed-tick measurement from that write.
- R10: Register map (word address): 0 load, 1 count (read-only, writes ignored), 2 divider, 3 task priority, 4 spurious vector, 5 destination format (bits 3:0), 8 + i vector entry i, with entry 0 as the timer. Read data for an address appears one clock after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 4 | Register word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the address presented one clock earlier |
| irq_pulse | output | 1 | Single-cycle expiry request |
| irq_vector | output | 8 | Vector that goes with the request |

## Verification
The assertions assume that the divider code does not change while a count is running. They also assume that the repeating bit only changes while the timer is idle or stopped. Under those conditions pulses are never back to back, always follow a zero count, and never occur while suppressed. To stay within this, the stimulus stops the timer with a zero load before it rewrites the divider or the mode. While a count runs, the stimulus changes only the suppress bit and the start value. A behavioural model of elapsed ticks then predicts the count and the pulse on every clock.

// File: rtl/lapic_timer_pkg.sv
package lapic_timer_pkg;

  localparam int SHIFT_W   = 3;
  localparam int MAX_SHIFT = 7;

  localparam int A_LOAD  = 0;
  localparam int A_COUNT = 1;
  localparam int A_DIV   = 2;
  localparam int A_TPRI  = 3;
  localparam int A_SPUR  = 4;
  localparam int A_DFMT  = 5;
  localparam int A_VEC0  = 8;

  typedef struct packed {
    logic       periodic;
    logic       masked;
    logic [7:0] vector;
  } vec_entry_t;

  localparam vec_entry_t ENTRY_RESET = '{periodic: 1'b0, masked: 1'b1, vector: 8'h00};

  function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [2:0] code);
    if (code == 3'd7) return '0;
    return SHIFT_W'(code) + SHIFT_W'(1);
  endfunction

  function automatic logic [31:0] entry_word(input vec_entry_t e);
    return {14'd0, e.periodic, e.masked, 8'd0, e.vector};
  endfunction

endpackage

// File: rtl/lapic_timer_regs.sv
module lapic_timer_regs
  import lapic_timer_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int CNT_W   = 32,
  parameter int NUM_VEC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               we,
  input  logic [31:0]        wdata,
  input  logic [CNT_W-1:0]   count_val,
  output logic [31:0]        rdata,
  output vec_entry_t         timer_entry,
  output logic [SHIFT_W-1:0] shift,
  output logic [CNT_W-1:0]   start_val,
  output logic               load
);

  logic [CNT_W-1:0] start_q, start_n;
  logic [2:0]       div_q, div_n;
  logic [7:0]       tpri_q, tpri_n;
  logic [7:0]       spur_q, spur_n;
  logic [3:0]       dfmt_q, dfmt_n;
  logic [31:0]      rdata_q, rdata_n;
  vec_entry_t       entry_q [NUM_VEC];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
    return a == ADDR_W'(target);
  endfunction

  always_comb begin
    load    = we && hit(addr, A_LOAD);
    start_n = load ? wdata[CNT_W-1:0] : start_q;
    div_n   = (we && hit(addr, A_DIV))  ? {wdata[3], wdata[1:0]} : div_q;
    tpri_n  = (we && hit(addr, A_TPRI)) ? wdata[7:0] : tpri_q;
    spur_n  = (we && hit(addr, A_SPUR)) ? wdata[7:0] : spur_q;
    dfmt_n  = (we && hit(addr, A_DFMT)) ? wdata[3:0] : dfmt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      div_q   <= '0;
      tpri_q  <= 8'h00;
      spur_q  <= 8'hFF;
      dfmt_q  <= 4'hF;
    end else begin
      start_q <= start_n;
      div_q   <= div_n;
      tpri_q  <= tpri_n;
      spur_q  <= spur_n;
      dfmt_q  <= dfmt_n;
    end
  end

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_entry
    logic       wr_en;
    vec_entry_t nxt;
    always_comb begin
      wr_en = we && hit(addr, A_VEC0 + g);
      nxt   = wr_en ? '{periodic: wdata[17], masked: wdata[16], vector: wdata[7:0]}
                    : entry_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) entry_q[g] <= ENTRY_RESET;
      else        entry_q[g] <= nxt;
    end
  end

  always_comb begin
    rdata_n = '0;
    if (hit(addr, A_LOAD))  rdata_n = 32'(start_q);
    if (hit(addr, A_COUNT)) rdata_n = 32'(count_val);
    if (hit(addr, A_DIV))   rdata_n = {28'd0, div_q[2], 1'b0, div_q[1:0]};
    if (hit(addr, A_TPRI))  rdata_n = {24'd0, tpri_q};
    if (hit(addr, A_SPUR))  rdata_n = {24'd0, spur_q};
    if (hit(addr, A_DFMT))  rdata_n = {28'd0, dfmt_q};
    for (int i = 0; i < NUM_VEC; i++) begin
      if (hit(addr, A_VEC0 + i)) rdata_n = entry_word(entry_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_n;
  end

  assign rdata       = rdata_q;
  assign timer_entry = entry_q[0];
  assign shift       = code_to_shift(div_q);
  assign start_val   = start_q;

  // R1: the timer entry leaves reset suppressed
  assert_entry_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> timer_entry.masked);

endmodule

// File: rtl/lapic_timer_prescale.sv
module lapic_timer_prescale
  import lapic_timer_pkg::*;
#(
  parameter int PRE_W = MAX_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);

  logic [PRE_W-1:0] pre_q, pre_n;
  logic [PRE_W-1:0] low_mask;

  always_comb begin
    low_mask = ~({PRE_W{1'b1}} << shift);
    pre_n    = restart ? '0 : pre_q + PRE_W'(1);
    tick     = (pre_q & low_mask) == low_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_n;
  end

  // R2: with a divide above one, ticks never fall on adjacent clocks
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && shift != '0 && !restart) |=> (!tick || !$stable(shift)));

endmodule

// File: rtl/lapic_timer_core.sv
module lapic_timer_core
  import lapic_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] start_val,
  input  vec_entry_t       entry,
  output logic [CNT_W-1:0] count,
  output logic             irq,
  output logic [7:0]       irq_vec
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             run_q, run_n;
  logic             irq_q, irq_n;
  logic [7:0]       vec_q, vec_n;

  always_comb begin
    cnt_n = cnt_q;
    run_n = run_q;
    irq_n = 1'b0;
    vec_n = vec_q;
    if (load) begin
      cnt_n = load_val;
      run_n = |load_val;
    end else if (tick && run_q) begin
      if (cnt_q == '0) begin
        irq_n = !entry.masked;
        if (!entry.masked) vec_n = entry.vector;
        if (entry.periodic) cnt_n = start_val;
        else                run_n = 1'b0;
      end else begin
        cnt_n = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      run_q <= run_n;
      irq_q <= irq_n;
      vec_q <= vec_n;
    end
  end

  assign count   = cnt_q;
  assign irq     = irq_q;
  assign irq_vec = vec_q;

  // R3: the count never exceeds the programmed start value
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= start_val);

  // R4: a request lasts one clock
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R4: a request only follows a zero count
  assert_fire_after_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(count) == '0);

  // R6: a zero start value never yields a request
  assert_zero_start_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(start_val) != '0);

  // R8: a suppressed entry yields no request
  assert_masked_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !$past(entry.masked));

endmodule

// File: rtl/lapic_timer.sv
module lapic_timer
  import lapic_timer_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int CNT_W   = 32,
  parameter int NUM_VEC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_pulse,
  output logic [7:0]        irq_vector
);

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  vec_entry_t         timer_entry;
  logic [SHIFT_W-1:0] shift;
  logic [CNT_W-1:0]   start_val;
  logic [CNT_W-1:0]   count_val;
  logic               load;
  logic               tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  lapic_timer_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_VEC(NUM_VEC)) regs_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .addr        (reg_addr),
    .we          (reg_we),
    .wdata       (reg_wdata),
    .count_val   (count_val),
    .rdata       (reg_rdata),
    .timer_entry (timer_entry),
    .shift       (shift),
    .start_val   (start_val),
    .load        (load)
  );

  lapic_timer_prescale #(.PRE_W(MAX_SHIFT)) pre_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .restart (load),
    .shift   (shift),
    .tick    (tick)
  );

  lapic_timer_core #(.CNT_W(CNT_W)) core_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick      (tick),
    .load      (load),
    .load_val  (reg_wdata[CNT_W-1:0]),
    .start_val (start_val),
    .entry     (timer_entry),
    .count     (count_val),
    .irq       (irq_pulse),
    .irq_vec   (irq_vector)
  );

endmodule

// File: tb/lapic_timer_tb_top.sv
module lapic_timer_tb_top;

  localparam int A_LOAD = 0, A_COUNT = 1, A_DIV = 2, A_TPRI = 3, A_SPUR = 4, A_DFMT = 5, A_VEC0 = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  always #4 clk = ~clk;

  lapic_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );

  int    n_run = 0, n_fail = 0, ec = 0, pulses = 0;
  int    m_load = 0, m_n = 0, m_s = 0, m_per = 0, m_mask = 1, m_vec = 0, m_loaded = 0;
  string tag = "R1";
  bit    finished = 0;

  function automatic int exp_count(int e);
    int d;
    if (!m_loaded || e < m_load) return 0;
    d = (e - m_load) >> m_s;
    if (m_per != 0) return (m_n == 0) ? 0 : m_n - (d % (m_n + 1));
    return (d >= m_n) ? 0 : m_n - d;
  endfunction

  function automatic bit exp_fire(int e);
    int rel, d;
    if (!m_loaded || m_n == 0 || m_mask != 0) return 0;
    rel = e - m_load;
    if (rel <= 0 || (rel % (1 << m_s)) != 0) return 0;
    d = rel >> m_s;
    if (m_per != 0) return (d % (m_n + 1)) == 0;
    return d == m_n + 1;
  endfunction

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h (edge %0d)", rq, what, act, exp, ec);
    end
  endtask

  task automatic step();
    logic [3:0] a_edge;
    bit f;
    a_edge = reg_addr;
    @(posedge clk);
    #1;
    ec++;
    f = exp_fire(ec);
    chk(irq_pulse == f, tag, "irq_pulse", irq_pulse, f);
    if (irq_pulse) pulses++;
    if (f) chk(irq_vector == 8'(m_vec), tag, "irq_vector", irq_vector, m_vec);
    if (a_edge == 4'(A_COUNT))
      chk(reg_rdata == 32'(exp_count(ec - 1)), tag, "count", reg_rdata, exp_count(ec - 1));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(int a, logic [31:0] d);
    reg_addr = 4'(a); reg_we = 1'b1; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_addr = 4'(A_COUNT);
  endtask

  task automatic rd(int a, logic [31:0] exp, string rq);
    reg_addr = 4'(a);
    step();
    chk(reg_rdata == exp, rq, "read", reg_rdata, exp);
    reg_addr = 4'(A_COUNT);
  endtask

  task automatic load(int n);
    wr(A_LOAD, 32'(n));
    m_load = ec; m_n = n; m_loaded = 1;
  endtask

  task automatic set_entry(int per, int mask, int vec);
    wr(A_VEC0, {14'd0, 1'(per), 1'(mask), 8'd0, 8'(vec)});
    m_per = per; m_mask = mask; m_vec = vec;
  endtask

  task automatic set_div(logic [31:0] code_word, int s);
    wr(A_DIV, code_word);
    m_s = s;
  endtask

  task automatic stop();
    load(0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 4'(A_COUNT); reg_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    run(3);

    // R1 reset defaults
    tag = "R1";
    for (int i = 0; i < 4; i++) rd(A_VEC0 + i, 32'h0001_0000, "R1");
    rd(A_LOAD, 0, "R1"); rd(A_COUNT, 0, "R1"); rd(A_DIV, 0, "R1");
    rd(A_TPRI, 0, "R1"); rd(A_SPUR, 32'hFF, "R1"); rd(A_DFMT, 32'hF, "R1");

    // R10 register map, read-only count
    tag = "R10";
    wr(A_COUNT, 32'h1234); rd(A_COUNT, 0, "R10");
    wr(A_TPRI, 32'h5A); rd(A_TPRI, 32'h5A, "R10");
    wr(A_DFMT, 32'h3); rd(A_DFMT, 32'h3, "R10");
    wr(A_VEC0 + 2, 32'h0002_0033); rd(A_VEC0 + 2, 32'h0002_0033, "R10");
    wr(A_DIV, 32'hB); m_s = 0; rd(A_DIV, 32'hB, "R10");

    // R3 / R4 single-shot, divide by one
    tag = "R3";
    set_entry(0, 0, 8'h41);
    pulses = 0; load(5); run(20);
    chk(pulses == 1, "R4", "one-shot pulse count", pulses, 1);
    rd(A_LOAD, 5, "R10");

    // R2 divide by 4 (code 001) then by 128 (code 110)
    tag = "R2";
    stop(); set_div(32'h1, 2);
    pulses = 0; load(3); run(30);
    chk(pulses == 1, "R2", "div4 pulse count", pulses, 1);
    stop(); set_div(32'hA, 7);
    pulses = 0; load(1); run(300);
    chk(pulses == 1, "R2", "div128 pulse count", pulses, 1);

    // R5 repeating
    tag = "R5";
    stop(); set_div(32'hB, 0); set_entry(1, 0, 8'h77);
    pulses = 0; load(3); run(30);
    chk(pulses == 7, "R5", "periodic pulse count", pulses, 7);
    stop(); set_div(32'h0, 1);
    load(2); run(40);

    // R6 repeating with zero start
    tag = "R6";
    stop(); set_div(32'hB, 0);
    pulses = 0; load(0); run(40);
    chk(pulses == 0, "R6", "zero periodic pulses", pulses, 0);

    // R8 suppression keeps counting
    tag = "R8";
    set_entry(1, 1, 8'h90);
    pulses = 0; load(2); run(12);
    chk(pulses == 0, "R8", "masked pulses", pulses, 0);
    set_entry(1, 0, 8'h90); run(12);

    // R7 zero load stops a single-shot
    tag = "R7";
    stop(); set_entry(0, 0, 8'h21);
    load(10); run(4);
    pulses = 0; stop(); run(30);
    chk(pulses == 0, "R7", "stopped pulses", pulses, 0);

    // R9 reload restarts the elapsed count
    tag = "R9";
    pulses = 0; load(6); run(3); load(6); run(20);
    chk(pulses == 1, "R9", "reload pulse count", pulses, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule